// File: doc/BRIEF.md
# NAND Flash Register Cycle Bridge

This block sits behind one 32-bit host register and turns each host access into raw cycles on an 8-bit NAND flash bus. A host write carries an operation code and a byte. The code picks a command-latch cycle, an address-latch cycle, a data-write cycle, or the arming of read mode. Once read mode is armed, every host read runs one flash read strobe and returns the captured byte. Every read word also carries the flash busy flag.

The host holds `bus_req` until the block answers with a one-clock `bus_ack`, and drops the request in that same cycle. The block accepts no new operation until the flash cycle in progress, including its hold clock, has finished. Strobe width is set by `PULSE_CLKS`. The ready/busy line is resynchronised through a flop chain of `SYNC_STAGES` stages before it is reported. The flash data bus is presented as a separate output, output enable and input, for a pad tristate outside the block.

Top module: `nand_reg_bridge`

## Requirements
- R1: After reset, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1, `nand_cle`, `nand_ale`, `nand_io_oe` and `bus_ack` are 0, and read mode is off.
- R2: A write with bits 30:28 = 0 produces one write strobe with CLE high and ALE low. A write with bits 30:28 = 1 produces one write strobe with ALE high and CLE low. In both cases `nand_io_out` carries bits 23:16 of the written word and `nand_io_oe` is 1.
- R3: Each write with bits 30:28 = 3 produces exactly one write strobe, with CLE and ALE low and bits 23:16 on the data bus. Consecutive such writes produce one strobe each, in order.
- R4: Write and read strobes stay low for exactly `PULSE_CLKS` clocks (3 by default). CLE, ALE, the data byte and the output enable are valid one clock before the strobe falls, and they stay unchanged until one clock after it rises.
- R5: CE# is low during every flash strobe. If bit 31 of a write is 1, CE# stays low after the operation. If bit 31 is 0, CE# returns high after the operation. This includes the read-arm operation, which drives CE# to the inverse of bit 31 at once.
- R6: A write with bits 30:28 = 2 arms read mode. Each later host read then makes one read strobe with `nand_io_oe` = 0, and returns the byte on `nand_io_in` at the clock where RE# rises, placed in bits 23:16.
- R7: A host read while read mode is off makes no strobe. Its word is zero except bit 15.
- R8: Bit 15 of every read word is 1 when the synchronised `nand_rb_n` is 0, and 0 when it is 1. All bits other than 23:16 and 15 read as zero.
- R9: `bus_ack` is a one-clock pulse. For a flash cycle, `bus_ack` is high in the clock that starts `PULSE_CLKS`+2 clocks after the accepting edge. For operations without a strobe, `bus_ack` is high in the clock right after the accepting edge.
- R10: A write with operation 0, 1 or 3 clears read mode. A write with bits 30:28 in 4 to 7 produces no strobe and leaves read mode and CE# unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Host access request, held until acknowledged |
| bus_wr | input | 1 | 1 for a register write, 0 for a read |
| bus_wdata | input | 32 | Written register word |
| bus_rdata | output | 32 | Read word, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-clock completion pulse |
| nand_ce_n | output | 1 | Flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven toward the flash |
| nand_io_oe | output | 1 | Output enable for the flash data pads |
| nand_io_in | input | 8 | Byte returned from the flash pads |
| nand_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
A flash cycle answers `bus_ack` `PULSE_CLKS`+2 clocks after the accepting edge, which is 5 clocks by default. An operation without a strobe answers one clock after that edge. The bus task counts falling edges from the request to the acknowledge and compares that count with 6 or 1. The busy flag lags `nand_rb_n` by the synchroniser depth, so the bench waits several clocks after changing that line before it reads. A pin monitor samples on falling edges. It checks the strobe width, the setup clock before a strobe falls and the hold clock after it rises, and it pops each strobe against the queue of cycles the driver expected.

// File: rtl/nand_bridge_pkg.sv
// Package: shared field positions, decoded request kinds, sequencer states
// and the packing of the host read word.
package nand_bridge_pkg;

    localparam int WORD_W   = 32;
    localparam int BYTE_W   = 8;
    localparam int CE_BIT   = 31;
    localparam int OP_LSB   = 28;
    localparam int OP_W     = 3;
    localparam int BYTE_LSB = 16;
    localparam int BUSY_BIT = 15;

    localparam logic [OP_W-1:0] OPC_CMD   = 3'd0;
    localparam logic [OP_W-1:0] OPC_ADDR  = 3'd1;
    localparam logic [OP_W-1:0] OPC_ARM   = 3'd2;
    localparam logic [OP_W-1:0] OPC_WDATA = 3'd3;

    typedef enum logic [2:0] {
        K_NOP, K_CMD, K_ADDR, K_WDATA, K_ARM, K_RDCYC, K_RDSTAT
    } req_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SETUP, S_STROBE, S_HOLD, S_ACK
    } seq_state_e;

    typedef struct packed {
        req_kind_e         kind;
        logic              hold_ce;
        logic [BYTE_W-1:0] data;
    } host_req_t;

    // Build the host read word from busy flag and byte; other bits zero.
    function automatic logic [WORD_W-1:0] pack_rword(input logic busy,
                                                     input logic [BYTE_W-1:0] b);
        logic [WORD_W-1:0] w;
        w = '0;
        w[BYTE_LSB +: BYTE_W] = b;
        w[BUSY_BIT] = busy;
        return w;
    endfunction

endpackage

// File: rtl/nb_rb_sync.sv
// Module: nb_rb_sync
// Resynchronises the asynchronous flash ready/busy line through a flop
// chain and presents it as an active-high busy flag.
// Assumes: STAGES >= 2; the line idles high (ready) out of reset.
module nb_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_n_async,
    output logic busy
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], rb_n_async};
    end

    assign busy = ~chain[STAGES-1];

endmodule

// File: rtl/nb_req_decode.sv
// Module: nb_req_decode
// Classifies a host access into a request kind and extracts the byte and
// chip-enable hold flag from the written word.
// Assumes: inputs are only consulted while a request is pending.
module nb_req_decode
    import nand_bridge_pkg::*;
(
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              armed,
    output host_req_t         req
);

    logic [OP_W-1:0] opc;
    assign opc = wdata[OP_LSB +: OP_W];

    // Map write opcodes and the read-mode flag to a request kind.
    always_comb begin
        req.data    = wdata[BYTE_LSB +: BYTE_W];
        req.hold_ce = wdata[CE_BIT];
        if (wr) begin
            case (opc)
                OPC_CMD:   req.kind = K_CMD;
                OPC_ADDR:  req.kind = K_ADDR;
                OPC_ARM:   req.kind = K_ARM;
                OPC_WDATA: req.kind = K_WDATA;
                default:   req.kind = K_NOP;
            endcase
        end else begin
            req.kind = armed ? K_RDCYC : K_RDSTAT;
        end
    end

endmodule

// File: rtl/nb_cycle_seq.sv
// Module: nb_cycle_seq
// Runs one flash bus cycle per accepted request: one setup clock, a strobe
// of PULSE_CLKS clocks, one hold clock, then a one-clock acknowledge.
// Requests without a strobe are acknowledged on the next clock.
// Assumes: the host drops req in the clock where ack is high.
module nb_cycle_seq
    import nand_bridge_pkg::*;
#(
    parameter int PULSE_CLKS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  host_req_t         req,
    input  logic              busy,
    input  logic [BYTE_W-1:0] io_in,
    output logic              armed,
    output logic              ack,
    output logic [WORD_W-1:0] rdata,
    output logic              ce_n,
    output logic              cle,
    output logic              ale,
    output logic              we_n,
    output logic              re_n,
    output logic [BYTE_W-1:0] io_out,
    output logic              io_oe
);

    localparam int CNT_W = $clog2(PULSE_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CLKS - 1);

    seq_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic              is_rd;
    logic              ce_hold;
    logic [BYTE_W-1:0] rd_byte;

    // Cycle sequencer: drives the flash pins and the host acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            is_rd   <= 1'b0;
            ce_hold <= 1'b0;
            armed   <= 1'b0;
            rd_byte <= '0;
            ack     <= 1'b0;
            rdata   <= '0;
            ce_n    <= 1'b1;
            cle     <= 1'b0;
            ale     <= 1'b0;
            we_n    <= 1'b1;
            re_n    <= 1'b1;
            io_out  <= '0;
            io_oe   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        case (req.kind)
                            K_CMD, K_ADDR, K_WDATA: begin
                                ce_n    <= 1'b0;
                                cle     <= (req.kind == K_CMD);
                                ale     <= (req.kind == K_ADDR);
                                io_out  <= req.data;
                                io_oe   <= 1'b1;
                                is_rd   <= 1'b0;
                                armed   <= 1'b0;
                                ce_hold <= req.hold_ce;
                                state   <= S_SETUP;
                            end
                            K_RDCYC: begin
                                ce_n  <= 1'b0;
                                is_rd <= 1'b1;
                                state <= S_SETUP;
                            end
                            K_ARM: begin
                                armed   <= 1'b1;
                                ce_hold <= req.hold_ce;
                                ce_n    <= ~req.hold_ce;
                                rdata   <= '0;
                                ack     <= 1'b1;
                                state   <= S_ACK;
                            end
                            K_RDSTAT: begin
                                rdata <= pack_rword(busy, '0);
                                ack   <= 1'b1;
                                state <= S_ACK;
                            end
                            default: begin
                                rdata <= '0;
                                ack   <= 1'b1;
                                state <= S_ACK;
                            end
                        endcase
                    end
                end
                S_SETUP: begin
                    if (is_rd) re_n <= 1'b0;
                    else       we_n <= 1'b0;
                    cnt   <= '0;
                    state <= S_STROBE;
                end
                S_STROBE: begin
                    if (cnt == CNT_LAST) begin
                        we_n  <= 1'b1;
                        re_n  <= 1'b1;
                        if (is_rd) rd_byte <= io_in;
                        state <= S_HOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                S_HOLD: begin
                    cle   <= 1'b0;
                    ale   <= 1'b0;
                    io_oe <= 1'b0;
                    ce_n  <= ~ce_hold;
                    rdata <= is_rd ? pack_rword(busy, rd_byte) : '0;
                    ack   <= 1'b1;
                    state <= S_ACK;
                end
                default: begin
                    ack   <= 1'b0;
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !re_n));
    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle && ale));
    // R6
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !re_n |-> !io_oe);
    // R5
    strobe_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || !re_n) |-> !ce_n);
    // R9
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R4
    data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(io_out) && $stable(cle) && $stable(ale)));
    // R4
    write_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(io_oe));

endmodule

// File: rtl/nand_reg_bridge.sv
// Module: nand_reg_bridge (top)
// One host register bridged to an 8-bit NAND flash bus. Decodes each host
// access, runs the matching flash cycle and reports data plus busy status.
// Assumes: host holds bus_req until bus_ack and drops it in that clock.
module nand_reg_bridge
    import nand_bridge_pkg::*;
#(
    parameter int PULSE_CLKS  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    output logic        nand_ce_n,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we_n,
    output logic        nand_re_n,
    output logic [7:0]  nand_io_out,
    output logic        nand_io_oe,
    input  logic [7:0]  nand_io_in,
    input  logic        nand_rb_n
);

    logic      busy;
    logic      armed;
    host_req_t dec_req;

    nb_rb_sync #(.STAGES(SYNC_STAGES)) rb_sync_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rb_n_async (nand_rb_n),
        .busy       (busy)
    );

    nb_req_decode req_dec_i (
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .armed (armed),
        .req   (dec_req)
    );

    nb_cycle_seq #(.PULSE_CLKS(PULSE_CLKS)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (bus_req),
        .req       (dec_req),
        .busy      (busy),
        .io_in     (nand_io_in),
        .armed     (armed),
        .ack       (bus_ack),
        .rdata     (bus_rdata),
        .ce_n      (nand_ce_n),
        .cle       (nand_cle),
        .ale       (nand_ale),
        .we_n      (nand_we_n),
        .re_n      (nand_re_n),
        .io_out    (nand_io_out),
        .io_oe     (nand_io_oe)
    );

    // R8
    rdata_unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (bus_rdata[31:24] == 8'h00 && bus_rdata[14:0] == 15'h0000));

endmodule

// File: tb/nand_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module nand_reg_bridge_tb_top;

    localparam int PULSE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
    logic [7:0]  nand_io_out;
    logic [7:0]  nand_io_in = 8'h00;
    logic        nand_rb_n = 1'b1;

    always #2.5 clk = ~clk;

    nand_reg_bridge #(.PULSE_CLKS(PULSE), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
        .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Scoreboard of expected strobes.
    typedef struct packed {
        logic       rd;
        logic       cle;
        logic       ale;
        logic [7:0] data;
    } strobe_t;

    strobe_t exp_q[$];
    int      strobe_cnt = 0;

    // Monitor: compare each strobe with the queue; check width, setup and hold.
    logic    prev_we = 1'b1, prev_re = 1'b1;
    strobe_t prev_pins, fall_pins;
    logic    prev_oe = 1'b0;
    int      low_cnt = 0;

    always @(negedge clk) begin
        strobe_t now;
        strobe_t e;
        now = '{rd: ~nand_re_n, cle: nand_cle, ale: nand_ale, data: nand_io_out};
        if (rst_n) begin
            if ((prev_we && !nand_we_n) || (prev_re && !nand_re_n)) begin
                strobe_cnt++;
                low_cnt = 1;
                fall_pins = now;
                chk(!nand_ce_n, "R5 ce low in strobe", {31'd0, nand_ce_n}, 32'd0);
                if (!nand_we_n) begin
                    chk(prev_pins[9:0] == now[9:0] && prev_oe,
                        "R4 setup before we fall", {22'd0, prev_pins[9:0]}, {22'd0, now[9:0]});
                    chk(nand_io_oe, "R2 oe in write", {31'd0, nand_io_oe}, 32'd1);
                end else begin
                    chk(!nand_io_oe, "R6 oe off in read", {31'd0, nand_io_oe}, 32'd0);
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected strobe", {21'd0, now}, 32'd0);
                end else begin
                    e = exp_q.pop_front();
                    if (e.rd)
                        chk(now.rd, "R6 read strobe", {21'd0, now}, {21'd0, e});
                    else
                        chk(now == e, "R3 write strobe", {21'd0, now}, {21'd0, e});
                end
            end else if (!nand_we_n || !nand_re_n) begin
                low_cnt++;
            end else if ((!prev_we && nand_we_n) || (!prev_re && nand_re_n)) begin
                chk(low_cnt == PULSE, "R4 strobe width", low_cnt, PULSE);
                if (!prev_we)
                    chk(now[9:0] == fall_pins[9:0] && nand_io_oe, "R4 hold after we rise",
                        {22'd0, now[9:0]}, {22'd0, fall_pins[9:0]});
            end
        end
        prev_we   = nand_we_n;
        prev_re   = nand_re_n;
        prev_pins = now;
        prev_oe   = nand_io_oe;
    end

    // Driver: one host access; returns read word and clocks until acknowledge.
    task automatic bus_xfer(input logic wr, input logic [31:0] wd,
                            output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_wr    = wr;
        bus_wdata = wd;
        waits = 0;
        do begin
            @(negedge clk);
            waits++;
        end while (!bus_ack && waits < 50);
        rd = bus_rdata;
        bus_req = 1'b0;
    endtask

    task automatic push_wr(input logic c, input logic a, input logic [7:0] d);
        exp_q.push_back('{rd: 1'b0, cle: c, ale: a, data: d});
    endtask

    task automatic push_rd();
        exp_q.push_back('{rd: 1'b1, cle: 1'b0, ale: 1'b0, data: 8'h00});
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int w;
        int base;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes/ce high", {29'd0, nand_ce_n, nand_we_n, nand_re_n}, 32'd7);
        chk(!nand_cle && !nand_ale && !nand_io_oe && !bus_ack, "R1 latches low",
            {28'd0, nand_cle, nand_ale, nand_io_oe, bus_ack}, 32'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1 / R7: read mode off after reset -> status only, no strobe
        bus_xfer(1'b0, 32'd0, rd, w);
        chk(rd == 32'h0, "R7 unarmed read word", rd, 32'h0);
        chk(w == 1, "R9 immediate ack", w, 1);

        // R2 command cycle, CE held (bit31)
        push_wr(1'b1, 1'b0, 8'h90);
        bus_xfer(1'b1, 32'h8090_0000, rd, w);
        chk(w == PULSE + 3, "R9 flash cycle ack timing", w, PULSE + 3);
        chk(!nand_ce_n, "R5 ce held after cmd", {31'd0, nand_ce_n}, 32'd0);

        // R2 address cycle
        push_wr(1'b0, 1'b1, 8'h5A);
        bus_xfer(1'b1, 32'h905A_0000, rd, w);
        chk(w == PULSE + 3, "R2 addr ack timing", w, PULSE + 3);

        // R3 streaming data writes
        base = strobe_cnt;
        push_wr(1'b0, 1'b0, 8'h11); bus_xfer(1'b1, 32'hB011_0000, rd, w);
        push_wr(1'b0, 1'b0, 8'h22); bus_xfer(1'b1, 32'hB022_0000, rd, w);
        push_wr(1'b0, 1'b0, 8'h33); bus_xfer(1'b1, 32'hB033_0000, rd, w);
        chk(strobe_cnt - base == 3, "R3 one strobe per write", strobe_cnt - base, 3);

        // R5 write without bit31 releases CE
        push_wr(1'b0, 1'b0, 8'h44);
        bus_xfer(1'b1, 32'h3044_0000, rd, w);
        chk(nand_ce_n, "R5 ce released", {31'd0, nand_ce_n}, 32'd1);

        // R6 arm read with CE held
        bus_xfer(1'b1, 32'hA000_0000, rd, w);
        chk(w == 1, "R9 arm ack timing", w, 1);
        chk(!nand_ce_n, "R5 arm drives ce low", {31'd0, nand_ce_n}, 32'd0);

        nand_io_in = 8'hC3;
        push_rd();
        bus_xfer(1'b0, 32'd0, rd, w);
        chk(rd == 32'h00C3_0000, "R6 read byte", rd, 32'h00C3_0000);
        chk(w == PULSE + 3, "R9 read cycle ack timing", w, PULSE + 3);

        // R8 busy while armed read
        nand_rb_n = 1'b0;
        repeat (4) @(negedge clk);
        nand_io_in = 8'h7E;
        push_rd();
        bus_xfer(1'b0, 32'd0, rd, w);
        chk(rd == 32'h007E_8000, "R8 busy with data", rd, 32'h007E_8000);
        nand_rb_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 data write clears read mode
        push_wr(1'b0, 1'b0, 8'h55);
        bus_xfer(1'b1, 32'hB055_0000, rd, w);
        base = strobe_cnt;
        bus_xfer(1'b0, 32'd0, rd, w);
        chk(strobe_cnt == base && w == 1, "R10 read mode cleared", strobe_cnt - base, 0);
        chk(rd == 32'h0, "R8 ready reads zero", rd, 32'h0);

        // R7 / R8 unarmed read while busy
        nand_rb_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_xfer(1'b0, 32'd0, rd, w);
        chk(rd == 32'h0000_8000, "R7 unarmed busy word", rd, 32'h0000_8000);
        nand_rb_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 undefined opcode: no strobe, CE unchanged (held low)
        base = strobe_cnt;
        bus_xfer(1'b1, 32'h5099_0000, rd, w);
        chk(strobe_cnt == base && w == 1, "R10 nop no strobe", strobe_cnt - base, 0);
        chk(!nand_ce_n, "R10 nop keeps ce", {31'd0, nand_ce_n}, 32'd0);

        // R5 arm without bit31 releases CE; R10 nop then keeps it high
        bus_xfer(1'b1, 32'h2000_0000, rd, w);
        chk(nand_ce_n, "R5 arm releases ce", {31'd0, nand_ce_n}, 32'd1);
        bus_xfer(1'b1, 32'hC000_0000, rd, w);
        chk(nand_ce_n, "R10 nop keeps ce high", {31'd0, nand_ce_n}, 32'd1);
        // R10 nop leaves read mode armed
        nand_io_in = 8'hA5;
        push_rd();
        bus_xfer(1'b0, 32'd0, rd, w);
        chk(rd == 32'h00A5_0000, "R10 nop keeps read mode", rd, 32'h00A5_0000);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all expected strobes seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule